// File: doc/BRIEF.md
# Lane-Partitioned Greater-Than Comparator

This block compares two 64-bit operands that hold packed sub-word lanes. A two-bit layout select decides how the 64 bits are divided: a single 64-bit lane, two 32-bit lanes, four 16-bit lanes or eight 8-bit lanes. Each lane compares its two values for greater-than on its own. A signedness select picks either unsigned or two's-complement interpretation. Results from one lane never affect a neighbouring lane.

The result is an 8-bit predicate with one bit for each byte slot of the operand. Every bit that covers a byte of a lane carries that lane's result. A consumer that masks by byte can therefore use the predicate directly, whatever the layout. Operands are captured on an input strobe. The predicate appears one clock later together with a valid flag.

Top module: `swar_gt_cmp`

## Requirements
- R1: A synchronous active-high reset clears the predicate output to 8'h00 and drives out_valid low.
- R2: When in_valid is high at a rising edge, out_valid is high after that edge. When in_valid is low at an edge, out_valid is low after it. When in_valid is low, the predicate holds its previous value.
- R3: With layout 2'b00 (one 64-bit lane), all eight predicate bits equal the scalar result a > b.
- R4: With layout 2'b01 (two 32-bit lanes), predicate bits [3:0] hold the result for a[31:0] > b[31:0], and bits [7:4] hold the result for a[63:32] > b[63:32].
- R5: With layout 2'b10 (four 16-bit lanes), predicate bits [2k+1:2k] hold the result for lane k, which is bits [16k+15:16k].
- R6: With layout 2'b11 (eight 8-bit lanes), predicate bit k holds the result for byte k.
- R7: When is_signed is 1, each lane is compared as two's complement, using only the top bit of that lane as its sign. When is_signed is 0, lanes are compared as unsigned.
- R8: The result of a lane does not depend on operand bits outside that lane. No borrow or carry crosses a lane boundary.
- R9: Within every lane, all predicate bits that cover that lane carry the same value.
- R10: Equal operands give a predicate of 8'h00 in every layout and signedness.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Capture strobe for the operands |
| layout | input | 2 | Lane layout: 00=1x64, 01=2x32, 10=4x16, 11=8x8 |
| is_signed | input | 1 | 1 selects two's-complement comparison |
| opa | input | 64 | Left operand |
| opb | input | 64 | Right operand |
| pred | output | 8 | Registered per-byte predicate |
| out_valid | output | 1 | Predicate was updated in the previous cycle |

## Verification
Random 64-bit operands almost never produce a wide lane whose upper bytes are equal, so the lower bytes rarely decide the result. Random data also rarely shows a boundary-crossing borrow or a sign bit that sits in an inner byte. For this reason the stimulus builds operands that share random upper bytes and differ only in one chosen byte. It also injects sign-boundary values such as 0x80 against 0x7F in each byte position. These are checked against a lane-wise reference in the bench that works on whole lane slices rather than byte chains.

// File: rtl/swar_gt_pkg.sv
package swar_gt_pkg;
  localparam int unsigned BYTE_W = 8;

  typedef enum logic [1:0] {
    LAY_1X64 = 2'b00,
    LAY_2X32 = 2'b01,
    LAY_4X16 = 2'b10,
    LAY_8X8  = 2'b11
  } layout_e;

  // bytes per lane for a layout
  function automatic int unsigned lane_bytes(input logic [1:0] lay);
    case (lay)
      2'b00:   lane_bytes = 8;
      2'b01:   lane_bytes = 4;
      2'b10:   lane_bytes = 2;
      default: lane_bytes = 1;
    endcase
  endfunction

  // 1 when byte slot k is the top byte of its lane
  function automatic logic is_lane_top(input logic [1:0] lay, input int unsigned k);
    int unsigned w;
    w = lane_bytes(lay);
    is_lane_top = ((k % w) == (w - 1));
  endfunction

  // 1 when byte slot k is the bottom byte of its lane
  function automatic logic is_lane_base(input logic [1:0] lay, input int unsigned k);
    is_lane_base = ((k % lane_bytes(lay)) == 0);
  endfunction
endpackage

// File: rtl/swar_byte_cmp.sv
module swar_byte_cmp #(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         sgn,
  output logic         gt,
  output logic         eq
);
  logic [W-1:0] a_adj;
  logic [W-1:0] b_adj;

  always_comb begin
    a_adj = a;
    b_adj = b;
    if (sgn) begin
      a_adj[W-1] = ~a[W-1];
      b_adj[W-1] = ~b[W-1];
    end
    gt = (a_adj > b_adj);
    eq = (a == b);
  end
endmodule

// File: rtl/swar_lane_chain.sv
module swar_lane_chain #(
  parameter int unsigned NB = 8
) (
  input  logic [1:0]    layout,
  input  logic [NB-1:0] byte_gt,
  input  logic [NB-1:0] byte_eq,
  output logic [NB-1:0] lane_top_gt,
  output logic [NB-1:0] top_mask
);
  import swar_gt_pkg::*;

  logic [NB-1:0] acc;
  logic [NB-1:0] cut;

  generate
    for (genvar k = 0; k < NB; k++) begin : g_chain
      assign cut[k]      = is_lane_base(layout, k);
      assign top_mask[k] = is_lane_top(layout, k);
      if (k == 0) begin : g_first
        assign acc[k] = byte_gt[k];
      end else begin : g_next
        // chain is cut at each active lane base
        assign acc[k] = byte_gt[k] | (byte_eq[k] & ~cut[k] & acc[k-1]);
      end
      assign lane_top_gt[k] = acc[k] & top_mask[k];
    end
  endgenerate
endmodule

// File: rtl/swar_pred_spread.sv
module swar_pred_spread #(
  parameter int unsigned NB = 8
) (
  input  logic [1:0]    layout,
  input  logic [NB-1:0] lane_top_gt,
  output logic [NB-1:0] pred
);
  import swar_gt_pkg::*;

  generate
    for (genvar k = 0; k < NB; k++) begin : g_spread
      always_comb begin
        int unsigned w;
        int unsigned top;
        w   = lane_bytes(layout);
        top = (k / w) * w + w - 1;
        pred[k] = lane_top_gt[top];
      end
    end
  endgenerate
endmodule

// File: rtl/swar_gt_cmp.sv
module swar_gt_cmp #(
  parameter int unsigned DATA_W = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [1:0]        layout,
  input  logic              is_signed,
  input  logic [DATA_W-1:0] opa,
  input  logic [DATA_W-1:0] opb,
  output logic [DATA_W/8-1:0] pred,
  output logic              out_valid
);
  import swar_gt_pkg::*;
  localparam int unsigned NB = DATA_W / BYTE_W;

  logic [NB-1:0] byte_gt;
  logic [NB-1:0] byte_eq;
  logic [NB-1:0] top_mask;
  logic [NB-1:0] lane_top_gt;
  logic [NB-1:0] pred_next;
  logic          op_equal;

  assign op_equal = (opa == opb);

  generate
    for (genvar k = 0; k < NB; k++) begin : g_bytes
      logic sgn_here;
      assign sgn_here = is_signed & top_mask[k];
      swar_byte_cmp #(.W(BYTE_W)) u_bc (
        .a  (opa[k*BYTE_W +: BYTE_W]),
        .b  (opb[k*BYTE_W +: BYTE_W]),
        .sgn(sgn_here),
        .gt (byte_gt[k]),
        .eq (byte_eq[k])
      );
    end
  endgenerate

  swar_lane_chain #(.NB(NB)) u_chain (
    .layout     (layout),
    .byte_gt    (byte_gt),
    .byte_eq    (byte_eq),
    .lane_top_gt(lane_top_gt),
    .top_mask   (top_mask)
  );

  swar_pred_spread #(.NB(NB)) u_spread (
    .layout     (layout),
    .lane_top_gt(lane_top_gt),
    .pred       (pred_next)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      pred      <= '0;
      out_valid <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) pred <= pred_next;
    end
  end

  // R10: equal operands never report greater
  a_r10_equal_is_false: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op_equal) |=> (pred == '0));

  // R2: valid follows strobe
  a_r2_valid_follows: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);

  a_r2_hold_pred: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(pred));

  // R3: single lane gives all-ones or all-zeros
  a_r3_scalar_uniform: assert property (@(posedge clk) disable iff (rst)
    (in_valid && layout == LAY_1X64) |=> (pred == '0 || pred == '1));

  // R9: lane bits uniform in 2x32
  a_r9_half_uniform: assert property (@(posedge clk) disable iff (rst)
    (in_valid && layout == LAY_2X32) |=>
      ((pred[3:0] == 4'h0 || pred[3:0] == 4'hF) && (pred[7:4] == 4'h0 || pred[7:4] == 4'hF)));

  // R5/R9: uniform pairs in 4x16
  a_r5_pair_uniform: assert property (@(posedge clk) disable iff (rst)
    (in_valid && layout == LAY_4X16) |=>
      (pred[0] == pred[1] && pred[2] == pred[3] && pred[4] == pred[5] && pred[6] == pred[7]));

  // R8: lane tops marked by chain match lane count
  a_r8_lane_count: assert property (@(posedge clk) disable iff (rst)
    $countones(top_mask) == (NB / lane_bytes(layout)));
endmodule

// File: tb/swar_gt_cmp_tb_top.sv
module swar_gt_cmp_tb_top;
  logic        clk = 1'b0;
  logic        rst;
  logic        in_valid;
  logic [1:0]  layout;
  logic        is_signed;
  logic [63:0] opa, opb;
  logic [7:0]  pred;
  logic        out_valid;
  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #10 clk = ~clk;

  swar_gt_cmp dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .layout(layout),
    .is_signed(is_signed), .opa(opa), .opb(opb), .pred(pred), .out_valid(out_valid)
  );

  function automatic logic [7:0] ref_pred(input logic [1:0] lay, input logic sg,
                                          input logic [63:0] a, input logic [63:0] b);
    int wbits, nl;
    logic [7:0] r;
    logic [63:0] la, lb;
    logic g;
    wbits = 64 >> lay;
    nl = 64 / wbits;
    r = '0;
    for (int l = 0; l < nl; l++) begin
      la = (a >> (l * wbits));
      lb = (b >> (l * wbits));
      if (wbits < 64) begin
        la = la & ((64'd1 << wbits) - 1);
        lb = lb & ((64'd1 << wbits) - 1);
      end
      if (sg) begin
        la = la ^ (64'd1 << (wbits - 1));
        lb = lb ^ (64'd1 << (wbits - 1));
      end
      g = (la > lb);
      for (int j = 0; j < wbits / 8; j++) r[l * (wbits / 8) + j] = g;
    end
    return r;
  endfunction

  function automatic string req_of(input logic [1:0] lay);
    case (lay)
      2'b00: return "R3";
      2'b01: return "R4";
      2'b10: return "R5";
      default: return "R6";
    endcase
  endfunction

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic apply(input string req, input logic [1:0] lay, input logic sg,
                       input logic [63:0] a, input logic [63:0] b);
    logic [7:0] e;
    e = ref_pred(lay, sg, a, b);
    @(negedge clk);
    in_valid = 1; layout = lay; is_signed = sg; opa = a; opb = b;
    @(negedge clk);
    in_valid = 0;
    check(req, pred, e);
    check("R2 valid", {7'd0, out_valid}, 8'd1);
  endtask

  initial begin
    #4000000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hang expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [63:0] a, b;
    logic [7:0] held;
    void'($urandom(32'd1234));
    rst = 1; in_valid = 0; layout = 0; is_signed = 0; opa = 0; opb = 0;
    repeat (3) @(negedge clk);
    check("R1 pred", pred, 8'h00);
    check("R1 valid", {7'd0, out_valid}, 8'd0);
    rst = 0;

    apply("R3 scalar", 2'b00, 0, 64'h8000_0000_0000_0000, 64'h7FFF_FFFF_FFFF_FFFF);
    apply("R7 scalar signed", 2'b00, 1, 64'h8000_0000_0000_0000, 64'h7FFF_FFFF_FFFF_FFFF);
    apply("R3 low byte decides", 2'b00, 0, 64'h1234_5678_9ABC_DE02, 64'h1234_5678_9ABC_DE01);
    apply("R4 lanes", 2'b01, 0, 64'h0000_0001_FFFF_FFFF, 64'h0000_0002_0000_0000);
    apply("R8 no borrow", 2'b01, 0, 64'h0000_0001_0000_0000, 64'h0000_0000_FFFF_FFFF);
    apply("R5 lanes", 2'b10, 1, 64'h8000_7FFF_0001_FFFF, 64'h7FFF_8000_0000_0000);
    apply("R6 bytes", 2'b11, 1, 64'h80_7F_01_FF_00_80_7F_10, 64'h7F_80_00_00_FF_7F_80_0F);
    apply("R6 unsigned", 2'b11, 0, 64'h80_7F_01_FF_00_80_7F_10, 64'h7F_80_00_00_FF_7F_80_0F);
    for (int l = 0; l < 4; l++) begin
      a = {$urandom, $urandom};
      apply("R10 equal", l[1:0], l[0], a, a);
    end

    // R2 hold: pred unchanged without strobe
    held = pred;
    @(negedge clk);
    layout = 2'b11; opa = '1; opb = '0;
    @(negedge clk);
    check("R2 hold", pred, held);
    check("R2 valid low", {7'd0, out_valid}, 8'd0);

    // R8/R7: single byte differs, rest shared random
    for (int i = 0; i < 64; i++) begin
      logic [1:0] lay;
      int k;
      a = {$urandom, $urandom};
      b = a;
      k = $urandom_range(0, 7);
      b[k*8 +: 8] = $urandom;
      if (i % 4 == 0) begin a[k*8 +: 8] = 8'h80; b[k*8 +: 8] = 8'h7F; end
      lay = i[1:0];
      apply(i[2] ? "R7 signed byte" : "R8 isolated byte", lay, i[2], a, b);
    end

    // random mix
    for (int i = 0; i < 300; i++) begin
      logic [1:0] lay;
      lay = $urandom_range(0, 3);
      a = {$urandom, $urandom};
      b = {$urandom, $urandom};
      apply(req_of(lay), lay, $urandom_range(0, 1), a, b);
    end

    // R9 uniform lanes checked on last result via reference shape
    check("R9 uniform", pred, ref_pred(layout, is_signed, opa, opb));

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule